// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the system clock into the 16x-oversampling enable pulse that a UART transmitter and receiver step on. The ratio between the system clock and sixteen times the baud rate is rarely an integer, so the divisor is split into a 16-bit whole part N and a 6-bit fraction F counted in sixty-fourths. A fraction accumulator stretches some intervals by one clock, so the pulse spacing alternates between N and N+1 clocks and averages N + F/64 over time.

Software writes the two divisor fields through simple write strobes and can read them back. A new divisor is held pending and is adopted only when the interval in progress ends, so a pulse interval never has a length that belongs to neither setting. A whole part of zero stops the pulse train.

An optional helper, selected by a parameter, works out both fields from a system clock frequency and a baud rate. It uses a bit-serial divider with a fixed latency, rounds the fraction to the nearest sixty-fourth, and clamps results that do not fit.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset, tick, both read-back fields, both in-force fields, calc_busy, calc_valid, calc_int and calc_frac are all zero.
- R2: While the in-force whole part is zero, tick stays low.
- R3: With fraction F = 0 and whole part N > 0, tick is a one-clock pulse that repeats every N clocks.
- R4: With N > 0 and fraction F, the first interval after enabling is N clocks, and the j-th following interval (j = 1, 2, ...) is N + floor(j*F/64) - floor((j-1)*F/64) clocks, so 64 consecutive intervals total 64*N + F clocks.
- R5: A write to either divisor field while ticks are running takes effect on the clock edge that emits the next tick, and the interval in progress keeps its old length; from the stopped state, the first tick appears on the (N+1)-th rising edge after the edge that captures the write.
- R6: rd_int and rd_frac show the last value written through wr_int_en and wr_frac_en from the clock edge after the write.
- R7: Writing a whole part of zero while running lets the interval in progress end with one final tick, after which tick stays low and act_int reads zero.
- R8: The helper returns I = floor(S / (16*B)) and F = floor((R*64 + floor(16*B/2)) / (16*B)) where R is the remainder; if F comes out as 64 it becomes 0 and I is incremented.
- R9: If the rounded whole part exceeds 65535, or B is zero, the helper returns 65535 and 63.
- R10: calc_valid is a one-clock pulse on the 39th rising edge after the edge that captures calc_start; calc_busy is high in between, and calc_start is ignored while calc_busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_int_en | input | 1 | Write strobe for the whole divisor part |
| wr_int_data | input | 16 | Whole divisor part to write |
| wr_frac_en | input | 1 | Write strobe for the fractional divisor part |
| wr_frac_data | input | 6 | Fractional divisor part to write, in sixty-fourths |
| rd_int | output | 16 | Last written whole part |
| rd_frac | output | 6 | Last written fractional part |
| act_int | output | 16 | Whole part currently in force |
| act_frac | output | 6 | Fractional part currently in force |
| tick | output | 1 | 16x-oversampling enable pulse |
| calc_start | input | 1 | Starts a divisor calculation |
| calc_sysclk | input | 32 | System clock frequency for the calculation |
| calc_baud | input | 24 | Baud rate for the calculation |
| calc_busy | output | 1 | Calculation in progress |
| calc_valid | output | 1 | One-clock pulse when results are ready |
| calc_int | output | 16 | Computed whole part |
| calc_frac | output | 6 | Computed fractional part |

## Verification
A table of clock and baud pairs drives the helper, and the results it holds are then loaded into the divisor so that the pulse spacing is measured over 64 intervals. The pairs cover an exact integer ratio, a divisor of one (a pulse every clock), a fraction of one half that alternates lengths, uneven fractions that separate a correct accumulator from one that drops or misplaces the carry, a remainder that rounds up into the whole part, a whole part of zero, an oversized ratio and a zero baud rate. Directed sequences then rewrite the divisor mid-interval to tell an update at the boundary from an immediate one, stop the pulse train, and fire a second start during a running calculation.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BAUD_INT_W  = 16;
  localparam int BAUD_FRAC_W = 6;
  localparam int BAUD_SYS_W  = 32;
  localparam int BAUD_RATE_W = 24;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int INT_W  = baud_pkg::BAUD_INT_W,
  parameter int FRAC_W = baud_pkg::BAUD_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_int_en,
  input  logic [INT_W-1:0]  wr_int_data,
  input  logic              wr_frac_en,
  input  logic [FRAC_W-1:0] wr_frac_data,
  output logic [INT_W-1:0]  pend_int,
  output logic [FRAC_W-1:0] pend_frac
);
  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q  <= '0;
      frac_q <= '0;
    end else begin
      if (wr_int_en)  int_q  <= wr_int_data;
      if (wr_frac_en) frac_q <= wr_frac_data;
    end
  end

  assign pend_int  = int_q;
  assign pend_frac = frac_q;

  AST_RD_INT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_int_en |=> (pend_int == $past(wr_int_data))); // R6
  AST_RD_FRAC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_frac_en |=> (pend_frac == $past(wr_frac_data))); // R6
endmodule

// File: rtl/baud_tick_core.sv
module baud_tick_core #(
  parameter int INT_W  = baud_pkg::BAUD_INT_W,
  parameter int FRAC_W = baud_pkg::BAUD_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  pend_int,
  input  logic [FRAC_W-1:0] pend_frac,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac,
  output logic              tick
);
  localparam int CNT_W = INT_W + 1;

  // fraction accumulator step: sum with carry in the top bit
  function automatic logic [FRAC_W:0] frac_accum(input logic [FRAC_W-1:0] acc,
                                                  input logic [FRAC_W-1:0] frac);
    return {1'b0, acc} + {1'b0, frac};
  endfunction

  // interval length: whole part, plus one clock when stretched
  function automatic logic [CNT_W-1:0] interval_len(input logic [INT_W-1:0] whole,
                                                     input logic stretch);
    return {1'b0, whole} + CNT_W'(stretch);
  endfunction

  logic              run_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [INT_W-1:0]  act_int_q;
  logic [FRAC_W-1:0] act_frac_q;
  logic              tick_q;

  // named internal events
  logic              start_w;
  logic              last_w;
  logic              stop_w;
  logic [FRAC_W:0]   acc_sum_w;
  logic              carry_w;

  assign start_w   = !run_q && (pend_int != '0);
  assign last_w    = run_q && (cnt_q == CNT_W'(1));
  assign stop_w    = last_w && (pend_int == '0);
  assign acc_sum_w = frac_accum(acc_q, pend_frac);
  assign carry_w   = acc_sum_w[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      cnt_q      <= '0;
      acc_q      <= '0;
      act_int_q  <= '0;
      act_frac_q <= '0;
      tick_q     <= 1'b0;
    end else if (start_w) begin
      run_q      <= 1'b1;
      cnt_q      <= interval_len(pend_int, 1'b0);
      acc_q      <= '0;
      act_int_q  <= pend_int;
      act_frac_q <= pend_frac;
      tick_q     <= 1'b0;
    end else if (last_w) begin
      tick_q     <= 1'b1;
      act_int_q  <= pend_int;
      act_frac_q <= pend_frac;
      if (stop_w) begin
        run_q <= 1'b0;
        cnt_q <= '0;
        acc_q <= '0;
      end else begin
        cnt_q <= interval_len(pend_int, carry_w);
        acc_q <= acc_sum_w[FRAC_W-1:0];
      end
    end else begin
      tick_q <= 1'b0;
      if (run_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end else begin
        act_int_q  <= pend_int;
        act_frac_q <= pend_frac;
      end
    end
  end

  assign act_int  = act_int_q;
  assign act_frac = act_frac_q;
  assign tick     = tick_q;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q) |=> !tick_q); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && cnt_q > CNT_W'(1)) |=> !tick_q); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0) && (cnt_q <= interval_len(act_int_q, 1'b1))); // R4
  AST_HOLD_MID_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !last_w) |=> ($stable(act_int_q) && $stable(act_frac_q))); // R5
  AST_STOP_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> (tick_q && !run_q && act_int_q == '0)); // R7
endmodule

// File: rtl/baud_calc_div.sv
module baud_calc_div #(
  parameter int SYS_W  = baud_pkg::BAUD_SYS_W,
  parameter int BAUD_W = baud_pkg::BAUD_RATE_W,
  parameter int INT_W  = baud_pkg::BAUD_INT_W,
  parameter int FRAC_W = baud_pkg::BAUD_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SYS_W-1:0]  sysclk,
  input  logic [BAUD_W-1:0] baud,
  output logic              busy,
  output logic              valid,
  output logic [INT_W-1:0]  res_int,
  output logic [FRAC_W-1:0] res_frac
);
  localparam int DIVR_W = BAUD_W + 4;              // sixteen times the baud rate
  localparam int DVD_W  = SYS_W + FRAC_W + 1;      // scaled dividend plus rounding headroom
  localparam int REM_W  = DIVR_W + 1;
  localparam int RES_W  = INT_W + FRAC_W;
  localparam int STEP_W = $clog2(DVD_W + 1);

  // sysclk * 2^FRAC_W + divisor/2: one division yields whole and rounded fraction
  function automatic logic [DVD_W-1:0] scaled_dividend(input logic [SYS_W-1:0] s,
                                                        input logic [DIVR_W-1:0] d);
    return {1'b0, s, {FRAC_W{1'b0}}} + DVD_W'(d >> 1);
  endfunction

  // clamp the combined quotient into whole and fraction fields
  function automatic logic [RES_W-1:0] clamp_result(input logic [DVD_W-1:0] q);
    if (q[DVD_W-1:RES_W] != '0) return '1;
    return q[RES_W-1:0];
  endfunction

  logic              busy_q;
  logic              valid_q;
  logic [STEP_W-1:0] step_q;
  logic [DIVR_W-1:0] rem_q;
  logic [DVD_W-1:0]  dvd_q;
  logic [DVD_W-2:0]  quo_q;
  logic [DIVR_W-1:0] dvsr_q;
  logic [RES_W-1:0]  res_q;

  // named internal events
  logic              accept_w;
  logic              final_w;
  logic [REM_W-1:0]  rem_sh_w;
  logic              ge_w;
  logic [DIVR_W-1:0] rem_nx_w;
  logic [DVD_W-1:0]  quo_nx_w;

  assign accept_w = start && !busy_q;
  assign final_w  = busy_q && (step_q == STEP_W'(1));
  assign rem_sh_w = {rem_q, dvd_q[DVD_W-1]};
  assign ge_w     = rem_sh_w >= {1'b0, dvsr_q};
  assign rem_nx_w = ge_w ? DIVR_W'(rem_sh_w - {1'b0, dvsr_q}) : rem_sh_w[DIVR_W-1:0];
  assign quo_nx_w = {quo_q, ge_w};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      step_q  <= '0;
      rem_q   <= '0;
      dvd_q   <= '0;
      quo_q   <= '0;
      dvsr_q  <= '0;
      res_q   <= '0;
    end else if (accept_w) begin
      busy_q  <= 1'b1;
      valid_q <= 1'b0;
      step_q  <= STEP_W'(DVD_W);
      rem_q   <= '0;
      quo_q   <= '0;
      dvsr_q  <= {baud, 4'b0000};
      dvd_q   <= scaled_dividend(sysclk, {baud, 4'b0000});
    end else if (busy_q) begin
      rem_q  <= rem_nx_w;
      dvd_q  <= dvd_q << 1;
      quo_q  <= quo_nx_w[DVD_W-2:0];
      step_q <= step_q - STEP_W'(1);
      if (final_w) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
        res_q   <= clamp_result(quo_nx_w);
      end else begin
        valid_q <= 1'b0;
      end
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign valid    = valid_q;
  assign res_int  = res_q[RES_W-1:FRAC_W];
  assign res_frac = res_q[FRAC_W-1:0];

  AST_CALC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R10
  AST_CALC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !valid_q); // R10
  AST_CALC_STEP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (step_q != '0 && step_q <= STEP_W'(DVD_W))); // R10
  AST_CALC_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !final_w) |=> ($stable(dvsr_q) && busy_q)); // R10
  AST_CALC_ZERO_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
    (final_w && dvsr_q == '0) |=> (res_int == '1 && res_frac == '1)); // R9
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
  parameter int SYS_W    = baud_pkg::BAUD_SYS_W,
  parameter int BAUD_W   = baud_pkg::BAUD_RATE_W,
  parameter int INT_W    = baud_pkg::BAUD_INT_W,
  parameter int FRAC_W   = baud_pkg::BAUD_FRAC_W,
  parameter bit HAS_CALC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_int_en,
  input  logic [INT_W-1:0]  wr_int_data,
  input  logic              wr_frac_en,
  input  logic [FRAC_W-1:0] wr_frac_data,
  output logic [INT_W-1:0]  rd_int,
  output logic [FRAC_W-1:0] rd_frac,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac,
  output logic              tick,
  input  logic              calc_start,
  input  logic [SYS_W-1:0]  calc_sysclk,
  input  logic [BAUD_W-1:0] calc_baud,
  output logic              calc_busy,
  output logic              calc_valid,
  output logic [INT_W-1:0]  calc_int,
  output logic [FRAC_W-1:0] calc_frac
);
  logic [INT_W-1:0]  pend_int;
  logic [FRAC_W-1:0] pend_frac;

  baud_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_int_en    (wr_int_en),
    .wr_int_data  (wr_int_data),
    .wr_frac_en   (wr_frac_en),
    .wr_frac_data (wr_frac_data),
    .pend_int     (pend_int),
    .pend_frac    (pend_frac)
  );

  assign rd_int  = pend_int;
  assign rd_frac = pend_frac;

  baud_tick_core #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_int  (pend_int),
    .pend_frac (pend_frac),
    .act_int   (act_int),
    .act_frac  (act_frac),
    .tick      (tick)
  );

  generate
    if (HAS_CALC) begin : g_calc
      baud_calc_div #(.SYS_W(SYS_W), .BAUD_W(BAUD_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (calc_start),
        .sysclk   (calc_sysclk),
        .baud     (calc_baud),
        .busy     (calc_busy),
        .valid    (calc_valid),
        .res_int  (calc_int),
        .res_frac (calc_frac)
      );
    end else begin : g_no_calc
      assign calc_busy  = 1'b0;
      assign calc_valid = 1'b0;
      assign calc_int   = '0;
      assign calc_frac  = '0;
    end
  endgenerate
endmodule

// File: tb/sim_baud_frac_gen.sv
module sim_baud_frac_gen;
  localparam int SYS_W = 32, BAUD_W = 24, INT_W = 16, FRAC_W = 6;
  localparam int CALC_LAT = SYS_W + FRAC_W + 1;
  localparam int NVEC = 9;
  // {sysclk, baud, expected whole, expected fraction}
  localparam logic [SYS_W+BAUD_W+INT_W+FRAC_W-1:0] VEC [NVEC] = '{
    {32'd1000000,    24'd9600,   16'd6,     6'd33},
    {32'd2000000,    24'd125000, 16'd1,     6'd0},
    {32'd3000000,    24'd62500,  16'd3,     6'd0},
    {32'd1000000,    24'd15000,  16'd4,     6'd11},
    {32'd1000,       24'd25,     16'd2,     6'd32},
    {32'd959,        24'd10,     16'd6,     6'd0},
    {32'd3,          24'd1,      16'd0,     6'd12},
    {32'hFFFF_FFFF,  24'd1,      16'hFFFF,  6'd63},
    {32'd1000,       24'd0,      16'hFFFF,  6'd63}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_int_en = 1'b0, wr_frac_en = 1'b0;
  logic [INT_W-1:0] wr_int_data = '0;
  logic [FRAC_W-1:0] wr_frac_data = '0;
  logic [INT_W-1:0] rd_int, act_int, calc_int;
  logic [FRAC_W-1:0] rd_frac, act_frac, calc_frac;
  logic tick, calc_busy, calc_valid;
  logic calc_start = 1'b0;
  logic [SYS_W-1:0] calc_sysclk = '0;
  logic [BAUD_W-1:0] calc_baud = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  baud_frac_gen u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_int_en(wr_int_en), .wr_int_data(wr_int_data),
    .wr_frac_en(wr_frac_en), .wr_frac_data(wr_frac_data),
    .rd_int(rd_int), .rd_frac(rd_frac), .act_int(act_int), .act_frac(act_frac),
    .tick(tick), .calc_start(calc_start), .calc_sysclk(calc_sysclk), .calc_baud(calc_baud),
    .calc_busy(calc_busy), .calc_valid(calc_valid), .calc_int(calc_int), .calc_frac(calc_frac)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [INT_W-1:0] n, input logic [FRAC_W-1:0] f);
    @(negedge clk);
    wr_int_en = 1'b1; wr_frac_en = 1'b1; wr_int_data = n; wr_frac_data = f;
    @(posedge clk); #1;
    wr_int_en = 1'b0; wr_frac_en = 1'b0;
  endtask

  // edges until tick is seen high
  task automatic wait_tick(input int lim, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!tick && n < lim);
  endtask

  task automatic quiet(input int len, output int hits);
    hits = 0;
    repeat (len) begin
      @(posedge clk); #1;
      if (tick) hits++;
    end
  endtask

  function automatic int exp_interval(input int n, input int f, input int j);
    return n + ((j * f) / 64) - (((j - 1) * f) / 64);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat, len, hits, bad, total;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(tick == 0 && rd_int == 0 && rd_frac == 0, "R1 reset tick/readback", {tick, rd_int, rd_frac}, 0);
    chk(act_int == 0 && act_frac == 0, "R1 reset in-force", {act_int, act_frac}, 0);
    chk(!calc_busy && !calc_valid && calc_int == 0 && calc_frac == 0, "R1 reset helper",
        {calc_busy, calc_valid, calc_int, calc_frac}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [SYS_W-1:0] s;
      logic [BAUD_W-1:0] b;
      logic [INT_W-1:0] en;
      logic [FRAC_W-1:0] ef;
      {s, b, en, ef} = VEC[i];
      @(negedge clk);
      calc_start = 1'b1; calc_sysclk = s; calc_baud = b;
      @(posedge clk); #1;
      calc_start = 1'b0;
      lat = 0;
      do begin @(posedge clk); #1; lat++; end while (!calc_valid && lat < 200);
      chk(lat == CALC_LAT, "R10 helper latency", lat, CALC_LAT);
      if (en == 16'hFFFF)
        chk(calc_int == en && calc_frac == ef, "R9 helper clamp", {calc_int, calc_frac}, {en, ef});
      else
        chk(calc_int == en && calc_frac == ef, "R8 helper result", {calc_int, calc_frac}, {en, ef});
      @(posedge clk); #1;
      chk(!calc_valid && !calc_busy, "R10 valid one clock", calc_valid, 0);

      if (en == 0) begin
        wr(calc_int, calc_frac);
        quiet(100, hits);
        chk(hits == 0, "R2 zero whole part gives no tick", hits, 0);
      end else if (en <= 64) begin
        wr(calc_int, calc_frac);
        wait_tick(200, len);
        chk(len == en + 1, "R5 first tick after enable", len, en + 1);
        bad = 0; total = 0;
        for (int j = 1; j <= 64; j++) begin
          wait_tick(200, len);
          total += len;
          if (len != exp_interval(en, ef, j)) bad++;
        end
        if (ef == 0) chk(bad == 0, "R3 fixed spacing", bad, 0);
        else         chk(bad == 0, "R4 dithered spacing", bad, 0);
        chk(total == 64 * en + ef, "R4 64-interval total", total, 64 * en + ef);
        wr(0, 0);
        repeat (2 * en + 8) @(posedge clk);
        #1;
      end
    end

    // mid-interval rewrite
    wr(10, 0);
    wait_tick(200, len);
    chk(len == 11, "R5 enable latency N=10", len, 11);
    wr(3, 5);
    chk(act_int == 10 && act_frac == 0, "R5 old divisor still in force", act_int, 10);
    chk(rd_int == 3 && rd_frac == 5, "R6 readback after write", {rd_int, rd_frac}, {16'd3, 6'd5});
    wait_tick(200, len);
    chk(len == 9, "R5 interval keeps old length", len, 9);
    chk(act_int == 3 && act_frac == 5, "R5 new divisor at tick", {act_int, act_frac}, {16'd3, 6'd5});
    wait_tick(200, len);
    chk(len == 3, "R5 new interval length", len, 3);
    // stop
    wr(0, 0);
    wait_tick(200, len);
    chk(len == 2, "R7 final tick ends interval", len, 2);
    quiet(40, hits);
    chk(hits == 0 && act_int == 0, "R7 stopped after final tick", hits, 0);

    // start ignored while busy
    @(negedge clk);
    calc_start = 1'b1; calc_sysclk = 32'd1000000; calc_baud = 24'd9600;
    @(posedge clk); #1;
    calc_start = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
      chk(calc_busy || calc_valid, "R10 busy while computing", calc_busy, 1);
      if (lat == 5) begin calc_start = 1'b1; calc_sysclk = 32'd3; calc_baud = 24'd1; end
      else calc_start = 1'b0;
    end while (!calc_valid && lat < 200);
    chk(lat == CALC_LAT, "R10 latency with second start", lat, CALC_LAT);
    chk(calc_int == 6 && calc_frac == 33, "R10 second start ignored", {calc_int, calc_frac}, {16'd6, 6'd33});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule